// File: doc/BRIEF.md
# Dual 40-bit Accumulator with Saturation

The block keeps two 40-bit accumulators, A and B, and shares one 40-bit adder/subtractor between them. Each operation names one accumulator, which is both the first operand and the destination. The second operand comes from one of three places: an external 40-bit word, such as a product from an upstream multiplier; the other accumulator; or nothing, in the case of negation. The external word can pass through an arithmetic barrel shifter before it is loaded or added.

Every result is checked for two kinds of overflow. The first is recoverable: the eight guard bits above bit 31 disagree. The second destroys the sign: the 40-bit result wrapped around. Each accumulator has its own sticky flag for each kind. Each kind can be enabled to raise a one-cycle trap pulse. When saturation is enabled, the value written back is clamped to either the 40-bit or the 32-bit signed range.

All results appear on the outputs one clock after the operation is presented.

Top module: `dual_acc_sat`

## Requirements
- R1: While `rst_n` is low, both accumulators, all four flags and `trap` are zero.
- R2: An operation writes only the accumulator chosen by `acc_sel` (0 = A, 1 = B), one clock after `op_valid`. The other accumulator keeps its value.
- R3: Three opcodes use the external operand: 3'd1 adds the shifted input, 3'd2 subtracts the unshifted input, and 3'd3 loads the shifted input. The arithmetic wraps modulo 2^40 when saturation is off.
- R4: `shift_amt` is a 5-bit two's complement number from -16 to +15. A positive value shifts the input right arithmetically. A negative value shifts it left, and bits moved out of the top are lost.
- R5: Three opcodes work between the accumulators. 3'd4 adds the other accumulator, 3'd5 subtracts the other accumulator, and 3'd6 negates the selected accumulator.
- R6: The guard flag of the destination is set when bits 39..32 of the unsaturated result are not all equal.
- R7: The sign flag of the destination is set when an add, subtract or negate overflows out of bit 39. A load never sets it.
- R8: Flags are sticky. Only `clr_flags` clears them. If `clr_flags` and a new overflow occur in the same cycle, the new overflow is kept.
- R9: `trap` pulses for one cycle, together with the write, when a guard overflow occurs while `trap_en_guard` is high, or when a sign overflow occurs while `trap_en_sign` is high.
- R10: When `sat_en=1` and `sat_32=0`, a sign-destroying overflow writes 0x7FFFFFFFFF if the true result is positive and 0x8000000000 if it is negative.
- R11: When `sat_en=1` and `sat_32=1`, any result outside the 32-bit signed range, including a wrapped one, is written as 0x007FFFFFFF or 0xFF80000000 according to its true sign.
- R12: Opcodes 3'd0 and 3'd7 change neither the accumulators nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute `op_code` this cycle |
| op_code | input | 3 | Operation select |
| acc_sel | input | 1 | Destination/source accumulator, 0 = A, 1 = B |
| data_in | input | 40 | External operand |
| shift_amt | input | 5 | Signed shift for the external operand |
| sat_en | input | 1 | Enable saturation of the write-back |
| sat_32 | input | 1 | Saturate to the 32-bit range instead of the 40-bit range |
| trap_en_guard | input | 1 | Allow guard overflow to raise `trap` |
| trap_en_sign | input | 1 | Allow sign overflow to raise `trap` |
| clr_flags | input | 1 | Clear all sticky flags |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| guard_a | output | 1 | Sticky guard overflow flag of A |
| guard_b | output | 1 | Sticky guard overflow flag of B |
| sign_a | output | 1 | Sticky sign overflow flag of A |
| sign_b | output | 1 | Sticky sign overflow flag of B |
| trap | output | 1 | One-cycle arithmetic trap pulse |

## Verification
Both accumulators and all flags are registered outputs, so any wrong internal value appears at the ports on the clock edge that writes it. A wrong operand mux, shift or carry therefore shows up one cycle after the operation. An overflow detector that misfires shows up as a flag that is wrong from then on until it is cleared, and as a trap pulse that appears or is missing in that same cycle. A wrong saturation choice shows up as a value that differs from a known clamp constant. Such an error can go unnoticed for several cycles only when the wrong value lands in an accumulator that is not read back until a later operation uses it.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic [2:0] {
    OP_NOP0    = 3'd0,
    OP_ADD_IN  = 3'd1,
    OP_SUB_IN  = 3'd2,
    OP_LOAD    = 3'd3,
    OP_ADD_OTH = 3'd4,
    OP_SUB_OTH = 3'd5,
    OP_NEG     = 3'd6,
    OP_NOP7    = 3'd7
  } dacc_op_e;
endpackage

// File: rtl/dacc_shifter.sv
module dacc_shifter #(
  parameter int W    = 40,
  parameter int SH_W = 5
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout
);
  localparam int MAG_W = SH_W + 1;

  logic [MAG_W-1:0] left_mag;

  always_comb begin
    left_mag = '0 - {amt[SH_W-1], amt};
    if (amt[SH_W-1]) begin
      dout = din << left_mag;
    end else begin
      dout = W'($signed(din) >>> amt);
    end
  end
endmodule

// File: rtl/dacc_addsub.sv
module dacc_addsub #(
  parameter int W     = 40,
  parameter int GUARD = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         subtract,
  input  logic         allow_ovf,
  output logic [W-1:0] res,
  output logic         true_neg,
  output logic         guard_ovf,
  output logic         sign_ovf
);
  localparam int GH = W - 1;
  localparam int GL = W - GUARD;

  logic [W-1:0] b_eff;
  logic [W:0]   wide_sum;
  logic [GUARD-1:0] guard_bits;

  always_comb begin
    b_eff      = subtract ? ~op_b : op_b;
    wide_sum   = {op_a[W-1], op_a} + {b_eff[W-1], b_eff} + {{W{1'b0}}, subtract};
    res        = wide_sum[W-1:0];
    true_neg   = wide_sum[W];
    guard_bits = res[GH:GL];
    guard_ovf  = !((guard_bits == '0) || (guard_bits == '1));
    sign_ovf   = allow_ovf && (op_a[W-1] == b_eff[W-1]) && (res[W-1] != op_a[W-1]);
  end
endmodule

// File: rtl/dacc_sat.sv
module dacc_sat #(
  parameter int W     = 40,
  parameter int GUARD = 8
) (
  input  logic [W-1:0] res,
  input  logic         true_neg,
  input  logic         sign_ovf,
  input  logic         sat_en,
  input  logic         sat_32,
  output logic [W-1:0] sat_out
);
  localparam int NW = W - GUARD;
  localparam logic [W-1:0] MAX_W = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_W = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_N = {{(GUARD+1){1'b0}}, {(NW-1){1'b1}}};
  localparam logic [W-1:0] MIN_N = {{(GUARD+1){1'b1}}, {(NW-1){1'b0}}};

  logic [GUARD:0] top_bits;
  logic           narrow_out;

  always_comb begin
    top_bits   = res[W-1:NW-1];
    narrow_out = !((top_bits == '0) || (top_bits == '1));
    sat_out    = res;
    if (sat_en) begin
      if (sat_32) begin
        if (sign_ovf || narrow_out) sat_out = true_neg ? MIN_N : MAX_N;
      end else if (sign_ovf) begin
        sat_out = true_neg ? MIN_W : MAX_W;
      end
    end
  end

  // R10
  sat_limit_chk: assert property (@(res) (sat_en && !sat_32 && sign_ovf) |->
                   ((sat_out == MAX_W) || (sat_out == MIN_W)));
endmodule

// File: rtl/dual_acc_sat.sv
module dual_acc_sat
  import dacc_pkg::*;
#(
  parameter int W     = 40,
  parameter int GUARD = 8,
  parameter int SH_W  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic          acc_sel,
  input  logic [W-1:0]  data_in,
  input  logic [SH_W-1:0] shift_amt,
  input  logic          sat_en,
  input  logic          sat_32,
  input  logic          trap_en_guard,
  input  logic          trap_en_sign,
  input  logic          clr_flags,
  output logic [W-1:0]  acc_a,
  output logic [W-1:0]  acc_b,
  output logic          guard_a,
  output logic          guard_b,
  output logic          sign_a,
  output logic          sign_b,
  output logic          trap
);
  localparam int NW = W - GUARD;

  logic [W-1:0] acc_a_q, acc_b_q, acc_a_d, acc_b_d;
  logic         guard_a_q, guard_b_q, sign_a_q, sign_b_q;
  logic         guard_a_d, guard_b_d, sign_a_d, sign_b_d;
  logic         trap_q, trap_d;

  logic [W-1:0] dst_val, oth_val, shifted;
  logic [W-1:0] opnd_a, opnd_b, sum_res, wb_val;
  logic         do_sub, allow_ovf, op_hit;
  logic         true_neg, guard_ovf, sign_ovf;
  logic         a_en, b_en;

  dacc_shifter #(.W(W), .SH_W(SH_W)) shift_i (
    .din(data_in), .amt(shift_amt), .dout(shifted)
  );

  always_comb begin
    dst_val   = acc_sel ? acc_b_q : acc_a_q;
    oth_val   = acc_sel ? acc_a_q : acc_b_q;
    opnd_a    = dst_val;
    opnd_b    = shifted;
    do_sub    = 1'b0;
    allow_ovf = 1'b1;
    op_hit    = op_valid;
    case (dacc_op_e'(op_code))
      OP_ADD_IN:  ;
      OP_SUB_IN:  begin opnd_b = data_in; do_sub = 1'b1; end
      OP_LOAD:    begin opnd_a = '0; allow_ovf = 1'b0; end
      OP_ADD_OTH: opnd_b = oth_val;
      OP_SUB_OTH: begin opnd_b = oth_val; do_sub = 1'b1; end
      OP_NEG:     begin opnd_a = '0; opnd_b = dst_val; do_sub = 1'b1; end
      default:    op_hit = 1'b0;
    endcase
  end

  dacc_addsub #(.W(W), .GUARD(GUARD)) addsub_i (
    .op_a(opnd_a), .op_b(opnd_b), .subtract(do_sub), .allow_ovf(allow_ovf),
    .res(sum_res), .true_neg(true_neg), .guard_ovf(guard_ovf), .sign_ovf(sign_ovf)
  );

  dacc_sat #(.W(W), .GUARD(GUARD)) sat_i (
    .res(sum_res), .true_neg(true_neg), .sign_ovf(sign_ovf),
    .sat_en(sat_en), .sat_32(sat_32), .sat_out(wb_val)
  );

  // next-state
  always_comb begin
    a_en      = op_hit && !acc_sel;
    b_en      = op_hit && acc_sel;
    acc_a_d   = a_en ? wb_val : acc_a_q;
    acc_b_d   = b_en ? wb_val : acc_b_q;
    guard_a_d = (guard_a_q && !clr_flags) || (a_en && guard_ovf);
    guard_b_d = (guard_b_q && !clr_flags) || (b_en && guard_ovf);
    sign_a_d  = (sign_a_q && !clr_flags) || (a_en && sign_ovf);
    sign_b_d  = (sign_b_q && !clr_flags) || (b_en && sign_ovf);
    trap_d    = op_hit && ((guard_ovf && trap_en_guard) || (sign_ovf && trap_en_sign));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a_q   <= '0;
      acc_b_q   <= '0;
      guard_a_q <= 1'b0;
      guard_b_q <= 1'b0;
      sign_a_q  <= 1'b0;
      sign_b_q  <= 1'b0;
      trap_q    <= 1'b0;
    end else begin
      acc_a_q   <= acc_a_d;
      acc_b_q   <= acc_b_d;
      guard_a_q <= guard_a_d;
      guard_b_q <= guard_b_d;
      sign_a_q  <= sign_a_d;
      sign_b_q  <= sign_b_d;
      trap_q    <= trap_d;
    end
  end

  assign acc_a   = acc_a_q;
  assign acc_b   = acc_b_q;
  assign guard_a = guard_a_q;
  assign guard_b = guard_b_q;
  assign sign_a  = sign_a_q;
  assign sign_b  = sign_b_q;
  assign trap    = trap_q;

  // R2
  unsel_b_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !acc_sel) |=> $stable(acc_b_q));
  // R2
  unsel_a_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && acc_sel) |=> $stable(acc_a_q));
  // R8
  guard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(guard_a_q) |-> $past(clr_flags));
  // R8
  sign_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sign_b_q) |-> $past(clr_flags));
  // R9
  trap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> (guard_a_q || guard_b_q || sign_a_q || sign_b_q));
  // R11
  narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !acc_sel && sat_en && sat_32 && (op_code != 3'd0) && (op_code != 3'd7)) |=>
    ((acc_a_q[W-1:NW-1] == '0) || (acc_a_q[W-1:NW-1] == '1)));
  // R6
  guard_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !acc_sel && !sat_en && (op_code != 3'd0) && (op_code != 3'd7)) |=>
    ((acc_a_q[W-1:NW] == '0) || (acc_a_q[W-1:NW] == '1) || guard_a_q));
endmodule

// File: tb/dual_acc_sat_tb_top.sv
module dual_acc_sat_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic        acc_sel;
  logic [39:0] data_in;
  logic [4:0]  shift_amt;
  logic        sat_en, sat_32, trap_en_guard, trap_en_sign, clr_flags;
  logic [39:0] acc_a, acc_b;
  logic        guard_a, guard_b, sign_a, sign_b, trap;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_acc_sat dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_sel(acc_sel), .data_in(data_in), .shift_amt(shift_amt),
    .sat_en(sat_en), .sat_32(sat_32), .trap_en_guard(trap_en_guard),
    .trap_en_sign(trap_en_sign), .clr_flags(clr_flags),
    .acc_a(acc_a), .acc_b(acc_b), .guard_a(guard_a), .guard_b(guard_b),
    .sign_a(sign_a), .sign_b(sign_b), .trap(trap)
  );

  task automatic chk40(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%010h expected=%010h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] code, input logic sel,
                       input logic [39:0] d, input logic [4:0] sh);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; acc_sel = sel; data_in = d; shift_amt = sh;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    clr_flags = 1'b1;
    @(negedge clk);
    clr_flags = 1'b0;
  endtask

  task automatic t_reset();
    chk40("R1 acc_a", acc_a, 40'h0);
    chk40("R1 acc_b", acc_b, 40'h0);
    chk1("R1 flags", guard_a | guard_b | sign_a | sign_b, 1'b0);
    chk1("R1 trap", trap, 1'b0);
  endtask

  task automatic t_load_shift();
    do_op(3'd3, 1'b0, 40'h0000001234, 5'd0);
    chk40("R3 load", acc_a, 40'h0000001234);
    do_op(3'd3, 1'b0, 40'h0000012340, 5'd4);
    chk40("R4 shift right", acc_a, 40'h0000001234);
    do_op(3'd3, 1'b0, 40'h0000000012, 5'b11000);
    chk40("R4 shift left 8", acc_a, 40'h0000001200);
    do_op(3'd3, 1'b0, 40'hFFFFFFFF00, 5'd4);
    chk40("R4 arith right", acc_a, 40'hFFFFFFFFF0);
    do_op(3'd3, 1'b0, 40'h0000001234, 5'd0);
  endtask

  task automatic t_ext_arith();
    do_op(3'd1, 1'b0, 40'h0000000010, 5'd0);
    chk40("R3 add in", acc_a, 40'h0000001244);
    do_op(3'd2, 1'b0, 40'h0000000044, 5'd0);
    chk40("R3 sub in", acc_a, 40'h0000001200);
    chk40("R2 b untouched", acc_b, 40'h0);
  endtask

  task automatic t_inter_acc();
    do_op(3'd3, 1'b1, 40'h0000000100, 5'd0);
    chk40("R2 a kept on b load", acc_a, 40'h0000001200);
    do_op(3'd4, 1'b0, 40'h0, 5'd0);
    chk40("R5 add other", acc_a, 40'h0000001300);
    do_op(3'd5, 1'b1, 40'h0, 5'd0);
    chk40("R5 sub other", acc_b, 40'hFFFFFFEE00);
    do_op(3'd6, 1'b0, 40'h0, 5'd0);
    chk40("R5 neg", acc_a, 40'hFFFFFFED00);
  endtask

  task automatic t_nop();
    do_op(3'd0, 1'b0, 40'h00FFFFFFFF, 5'd0);
    do_op(3'd7, 1'b1, 40'h00FFFFFFFF, 5'd0);
    chk40("R12 nop a", acc_a, 40'hFFFFFFED00);
    chk40("R12 nop b", acc_b, 40'hFFFFFFEE00);
  endtask

  task automatic t_overflow_flags();
    clear_flags();
    do_op(3'd3, 1'b0, 40'h007FFFFFFF, 5'd0);
    do_op(3'd1, 1'b0, 40'h0000000001, 5'd0);
    chk40("R6 no-guard value", acc_a, 40'h0080000000);
    chk1("R6 guard clear", guard_a, 1'b0);
    do_op(3'd1, 1'b0, 40'h0100000000, 5'd0);
    chk40("R6 guard value", acc_a, 40'h0180000000);
    chk1("R6 guard set", guard_a, 1'b1);
    chk1("R7 sign clear", sign_a, 1'b0);
    do_op(3'd3, 1'b1, 40'h7FFFFFFFFF, 5'd0);
    chk1("R7 load no sign", sign_b, 1'b0);
    do_op(3'd1, 1'b1, 40'h0000000001, 5'd0);
    chk40("R7 wrap", acc_b, 40'h8000000000);
    chk1("R7 sign set", sign_b, 1'b1);
    chk1("R6 guard b set", guard_b, 1'b1);
    do_op(3'd3, 1'b1, 40'h0, 5'd0);
    chk1("R8 sign sticky", sign_b, 1'b1);
    chk1("R8 guard sticky", guard_a, 1'b1);
    clear_flags();
    chk1("R8 cleared", guard_a | guard_b | sign_a | sign_b, 1'b0);
  endtask

  task automatic t_clear_vs_set();
    do_op(3'd3, 1'b0, 40'h0, 5'd0);
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd1; acc_sel = 1'b0;
    data_in = 40'h0100000000; shift_amt = 5'd0; clr_flags = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; clr_flags = 1'b0;
    chk1("R8 set wins over clear", guard_a, 1'b1);
    clear_flags();
  endtask

  task automatic t_neg_min();
    do_op(3'd3, 1'b0, 40'h8000000000, 5'd0);
    do_op(3'd6, 1'b0, 40'h0, 5'd0);
    chk40("R7 neg min wraps", acc_a, 40'h8000000000);
    chk1("R7 neg min sign", sign_a, 1'b1);
    sat_en = 1'b1;
    do_op(3'd6, 1'b0, 40'h0, 5'd0);
    chk40("R10 neg min sat", acc_a, 40'h7FFFFFFFFF);
    sat_en = 1'b0;
    clear_flags();
  endtask

  task automatic t_sat40();
    sat_en = 1'b1; sat_32 = 1'b0;
    do_op(3'd3, 1'b0, 40'h7FFFFFFFFF, 5'd0);
    do_op(3'd1, 1'b0, 40'h0000000005, 5'd0);
    chk40("R10 pos clamp", acc_a, 40'h7FFFFFFFFF);
    chk1("R10 sign flag", sign_a, 1'b1);
    do_op(3'd3, 1'b1, 40'h8000000000, 5'd0);
    do_op(3'd2, 1'b1, 40'h0000000001, 5'd0);
    chk40("R10 neg clamp", acc_b, 40'h8000000000);
    do_op(3'd3, 1'b0, 40'h0100000000, 5'd0);
    chk40("R10 guard-only no clamp", acc_a, 40'h0100000000);
    sat_en = 1'b0;
    clear_flags();
  endtask

  task automatic t_sat32();
    sat_en = 1'b1; sat_32 = 1'b1;
    do_op(3'd3, 1'b0, 40'h007FFFFFFF, 5'd0);
    do_op(3'd1, 1'b0, 40'h0000000001, 5'd0);
    chk40("R11 pos clamp", acc_a, 40'h007FFFFFFF);
    do_op(3'd3, 1'b0, 40'hFF80000000, 5'd0);
    do_op(3'd2, 1'b0, 40'h0000000001, 5'd0);
    chk40("R11 neg clamp", acc_a, 40'hFF80000000);
    do_op(3'd3, 1'b1, 40'h0100000000, 5'd0);
    chk40("R11 load clamp", acc_b, 40'h007FFFFFFF);
    do_op(3'd3, 1'b1, 40'h0000001000, 5'd0);
    chk40("R11 in range", acc_b, 40'h0000001000);
    sat_en = 1'b0; sat_32 = 1'b0;
    clear_flags();
  endtask

  task automatic t_trap();
    trap_en_guard = 1'b1; trap_en_sign = 1'b0;
    do_op(3'd3, 1'b0, 40'h0, 5'd0);
    chk1("R9 no trap", trap, 1'b0);
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd1; acc_sel = 1'b0; data_in = 40'h0100000000; shift_amt = 5'd0;
    @(negedge clk);
    op_valid = 1'b0;
    chk1("R9 guard trap", trap, 1'b1);
    @(negedge clk);
    chk1("R9 single pulse", trap, 1'b0);
    trap_en_guard = 1'b0; trap_en_sign = 1'b1;
    do_op(3'd1, 1'b0, 40'h0100000000, 5'd0);
    chk1("R9 guard masked", trap, 1'b0);
    do_op(3'd3, 1'b1, 40'h7FFFFFFFFF, 5'd0);
    do_op(3'd1, 1'b1, 40'h0000000001, 5'd0);
    chk1("R9 sign trap", trap, 1'b1);
    trap_en_sign = 1'b0;
    do_op(3'd1, 1'b1, 40'h8000000000, 5'd0);
    chk1("R9 sign masked", trap, 1'b0);
    clear_flags();
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0; acc_sel = 1'b0;
    data_in = '0; shift_amt = '0; sat_en = 1'b0; sat_32 = 1'b0;
    trap_en_guard = 1'b0; trap_en_sign = 1'b0; clr_flags = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_load_shift();
    t_ext_arith();
    t_inter_acc();
    t_nop();
    t_overflow_flags();
    t_clear_vs_set();
    t_neg_min();
    t_sat40();
    t_sat32();
    t_trap();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule